// File: doc/BRIEF.md
# VLIW Packet Dispatcher

This block takes one 32-bit fetched instruction word and issues its contents, one slot at a time, to a two-slot execute stage. The two top bits of the word choose how it issues. The word can be one long instruction. It can be a pair of 15-bit short instructions run one after the other, with either the left half or the right half first. Or it can be a pair of short instructions meant to run in parallel. The block issues the first instruction, waits for the execute stage to return `done` with its feedback, and then decides whether the second instruction issues at all.

In parallel mode a half may be a test-only instruction that produces a condition. A 64-bit lookup vector, indexed by the 6-bit opcode field of a short half, says which opcodes are test-only. A test-only half issues first, and its condition result decides whether the other half runs. Three counters record pairs cut short by a taken branch, gated halves that ran, and gated halves that were dropped.

States: `ST_IDLE` (ready for a word), `ST_ISSUE_A` (first strobe), `ST_WAIT_A` (wait for first done), `ST_ISSUE_B` (second strobe), `ST_WAIT_B` (wait for second done). Transitions: IDLE→ISSUE_A when a word is accepted; ISSUE_A→WAIT_A always; WAIT_A→IDLE on done when no second slot is due; WAIT_A→ISSUE_B on done when the second slot is due; ISSUE_B→WAIT_B always; WAIT_B→IDLE on done.

Top module: `pkt_dispatch`

## Requirements
- R1: After synchronous reset `in_ready` is 1, `iss_valid` is 0 and all three counters read 0.
- R2: Top bits `11` give one issue with `iss_tag`=3 (long) and payload = word bits 29:0. The block then returns to idle.
- R3: Top bits `10` issue the right half (bits 14:0, tag 2) first and the left half (bits 29:15, tag 1) second. Top bits `01` issue the left half first and the right half second.
- R4: In sequential mode the second half issues only if the first done returns with `pc_changed`=0 and `exception`=0. `cnt_skip` increments by 1 exactly when `pc_changed`=1 and `exception`=0.
- R5: In parallel mode (top bits `00`), if the left half's opcode is test-only, the left half issues first. The right half issues only if `cond_true`=1 at the first done. `cnt_true` counts the halves that ran this way and `cnt_false` counts the halves that were dropped. `exception` has no effect here.
- R6: In parallel mode, if the left half is not test-only but the right half is, the right half issues first and gates the left half, with the same counting as R5.
- R7: In parallel mode with neither half test-only, the left half issues first. The right half follows unless `exception`=1 at the first done.
- R8: `iss_index` is payload bits 29:24 for a long issue and bits 14:9 of the half for a short issue. Test-only status of a half is `test_only_map[half bits 14:9]`.
- R9: Each issue strobe lasts exactly one cycle. The next issue comes only after `done`. A `word_valid` while busy is ignored.
- R10: `in_ready` is high only in idle. While it is high no issue strobe is active, and a word is accepted on a cycle with `word_valid` and `in_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Fetched word present |
| word_in | input | 32 | Fetched instruction word |
| test_only_map | input | 64 | Test-only flag per short opcode index |
| in_ready | output | 1 | Block idle, word can be accepted |
| iss_valid | output | 1 | One-cycle issue strobe |
| iss_tag | output | 2 | 1 left half, 2 right half, 3 long |
| iss_payload | output | 30 | Issued instruction, short halves zero-extended |
| iss_index | output | 6 | Opcode lookup index of the issued instruction |
| done | input | 1 | Execute stage finished the issued instruction |
| pc_changed | input | 1 | Issued instruction changed the PC |
| exception | input | 1 | Issued instruction raised an exception |
| cond_true | input | 1 | Condition result of a test-only instruction |
| cnt_skip | output | 16 | Sequential second halves skipped by a branch |
| cnt_true | output | 16 | Gated halves issued |
| cnt_false | output | 16 | Gated halves dropped |

## Verification
The hardest case to reach is the choice among the parallel sub-cases. It depends on the decode lookup and on both halves' opcode fields together, and the result only shows after the first done returns with a given condition or exception. The bench builds words whose left and right opcode indices differ. It sets lookup bits for one, both or neither of them, adds decoy bits at nearby indices, and sweeps every mix of pc_changed, exception and condition feedback across all four top-bit modes. Part of the sweep also drives a stray word while the block is busy.

// File: rtl/pkt_dispatch_pkg.sv
package pkt_dispatch_pkg;
    typedef enum logic [1:0] {
        K_LONG = 2'd0,
        K_SEQ  = 2'd1,
        K_COND = 2'd2,
        K_PAR  = 2'd3
    } pkt_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ISSUE_A = 3'd1,
        ST_WAIT_A  = 3'd2,
        ST_ISSUE_B = 3'd3,
        ST_WAIT_B  = 3'd4
    } disp_state_e;

    localparam logic [1:0] TAG_LEFT  = 2'd1;
    localparam logic [1:0] TAG_RIGHT = 2'd2;
    localparam logic [1:0] TAG_LONG  = 2'd3;
endpackage

// File: rtl/pkt_classify.sv
module pkt_classify
    import pkt_dispatch_pkg::*;
#(
    parameter int HALF_W  = 15,
    parameter int IDX_W   = 6,
    parameter int IDX_LSB = 9,
    localparam int PAY_W  = 2 * HALF_W,
    localparam int WORD_W = PAY_W + 2,
    localparam int MAP_N  = 1 << IDX_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic [MAP_N-1:0]  map,
    output pkt_kind_e         kind,
    output logic [PAY_W-1:0]  pay_a,
    output logic [PAY_W-1:0]  pay_b,
    output logic [1:0]        tag_a,
    output logic [1:0]        tag_b
);
    logic [HALF_W-1:0] left_h, right_h;
    logic              left_test, right_test;
    logic [PAY_W-1:0]  left_ext, right_ext;

    assign left_h     = word[PAY_W-1:HALF_W];
    assign right_h    = word[HALF_W-1:0];
    assign left_ext   = PAY_W'(left_h);
    assign right_ext  = PAY_W'(right_h);
    assign left_test  = map[left_h[IDX_LSB +: IDX_W]];
    assign right_test = map[right_h[IDX_LSB +: IDX_W]];

    always_comb begin
        kind  = K_PAR;
        pay_a = left_ext;
        pay_b = right_ext;
        tag_a = TAG_LEFT;
        tag_b = TAG_RIGHT;
        unique case (word[WORD_W-1 -: 2])
            2'b11: begin
                kind  = K_LONG;
                pay_a = word[PAY_W-1:0];
                tag_a = TAG_LONG;
            end
            2'b10: begin
                kind  = K_SEQ;
                pay_a = right_ext;
                tag_a = TAG_RIGHT;
                pay_b = left_ext;
                tag_b = TAG_LEFT;
            end
            2'b01: kind = K_SEQ;
            2'b00: begin
                if (left_test) begin
                    kind = K_COND;
                end else if (right_test) begin
                    kind  = K_COND;
                    pay_a = right_ext;
                    tag_a = TAG_RIGHT;
                    pay_b = left_ext;
                    tag_b = TAG_LEFT;
                end else begin
                    kind = K_PAR;
                end
            end
        endcase
    end
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pkt_dispatch.sv
module pkt_dispatch
    import pkt_dispatch_pkg::*;
#(
    parameter int HALF_W  = 15,
    parameter int IDX_W   = 6,
    parameter int IDX_LSB = 9,
    parameter int CNT_W   = 16,
    localparam int PAY_W  = 2 * HALF_W,
    localparam int WORD_W = PAY_W + 2,
    localparam int MAP_N  = 1 << IDX_W,
    localparam int N_CNT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  logic [MAP_N-1:0]  test_only_map,
    output logic              in_ready,
    output logic              iss_valid,
    output logic [1:0]        iss_tag,
    output logic [PAY_W-1:0]  iss_payload,
    output logic [IDX_W-1:0]  iss_index,
    input  logic              done,
    input  logic              pc_changed,
    input  logic              exception,
    input  logic              cond_true,
    output logic [CNT_W-1:0]  cnt_skip,
    output logic [CNT_W-1:0]  cnt_true,
    output logic [CNT_W-1:0]  cnt_false
);
    disp_state_e state_q, state_d;
    pkt_kind_e   c_kind, kind_q;
    logic [PAY_W-1:0] c_pay_a, c_pay_b, pay_a_q, pay_b_q;
    logic [1:0]       c_tag_a, c_tag_b, tag_a_q, tag_b_q;
    logic [N_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_val [N_CNT];
    logic             accept;

    pkt_classify #(.HALF_W(HALF_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_cls (
        .word  (word_in),
        .map   (test_only_map),
        .kind  (c_kind),
        .pay_a (c_pay_a),
        .pay_b (c_pay_b),
        .tag_a (c_tag_a),
        .tag_b (c_tag_b)
    );

    genvar gi;
    generate
        for (gi = 0; gi < N_CNT; gi++) begin : g_cnt
            evt_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk (clk),
                .rst (rst),
                .inc (cnt_inc[gi]),
                .cnt (cnt_val[gi])
            );
        end
    endgenerate

    assign cnt_skip  = cnt_val[0];
    assign cnt_true  = cnt_val[1];
    assign cnt_false = cnt_val[2];
    assign accept    = (state_q == ST_IDLE) && word_valid;

    // state register and packet capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= K_LONG;
            pay_a_q <= '0;
            pay_b_q <= '0;
            tag_a_q <= TAG_LONG;
            tag_b_q <= TAG_LONG;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q  <= c_kind;
                pay_a_q <= c_pay_a;
                pay_b_q <= c_pay_b;
                tag_a_q <= c_tag_a;
                tag_b_q <= c_tag_b;
            end
        end
    end

    // next state and counter events
    always_comb begin
        state_d = state_q;
        cnt_inc = '0;
        unique case (state_q)
            ST_IDLE:    if (word_valid) state_d = ST_ISSUE_A;
            ST_ISSUE_A: state_d = ST_WAIT_A;
            ST_WAIT_A: begin
                if (done) begin
                    state_d = ST_IDLE;
                    unique case (kind_q)
                        K_LONG: state_d = ST_IDLE;
                        K_SEQ: begin
                            if (!pc_changed && !exception) state_d = ST_ISSUE_B;
                            cnt_inc[0] = pc_changed && !exception;
                        end
                        K_COND: begin
                            if (cond_true) state_d = ST_ISSUE_B;
                            cnt_inc[1] = cond_true;
                            cnt_inc[2] = !cond_true;
                        end
                        K_PAR: if (!exception) state_d = ST_ISSUE_B;
                    endcase
                end
            end
            ST_ISSUE_B: state_d = ST_WAIT_B;
            ST_WAIT_B:  if (done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready    = 1'b0;
        iss_valid   = 1'b0;
        iss_tag     = tag_a_q;
        iss_payload = pay_a_q;
        unique case (state_q)
            ST_IDLE:    in_ready  = 1'b1;
            ST_ISSUE_A: iss_valid = 1'b1;
            ST_ISSUE_B: begin
                iss_valid   = 1'b1;
                iss_tag     = tag_b_q;
                iss_payload = pay_b_q;
            end
            ST_WAIT_A:  ;
            ST_WAIT_B: begin
                iss_tag     = tag_b_q;
                iss_payload = pay_b_q;
            end
            default: ;
        endcase
        iss_index = (iss_tag == TAG_LONG) ? iss_payload[PAY_W-1 -: IDX_W]
                                          : iss_payload[IDX_LSB +: IDX_W];
    end
endmodule

// File: rtl/pkt_dispatch_chk.sv
module pkt_dispatch_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             iss_valid,
    input logic [1:0]       iss_tag,
    input logic             done,
    input logic             pc_changed,
    input logic             exception,
    input logic             cond_true,
    input logic [CNT_W-1:0] cnt_skip,
    input logic [CNT_W-1:0] cnt_true,
    input logic [CNT_W-1:0] cnt_false
);
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> !iss_valid); // R9
    AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !iss_valid); // R10
    AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (iss_tag != 2'b00)); // R2
    AST_SKIP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (cnt_skip != $past(cnt_skip)) |-> $past(done && pc_changed && !exception)); // R4
    AST_TRUE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (cnt_true != $past(cnt_true)) |-> $past(done && cond_true)); // R5
    AST_FALSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (cnt_false != $past(cnt_false)) |-> $past(done && !cond_true)); // R5
    AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !((cnt_true != $past(cnt_true)) && (cnt_false != $past(cnt_false)))); // R6
endmodule

bind pkt_dispatch pkt_dispatch_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .iss_valid  (iss_valid),
    .iss_tag    (iss_tag),
    .done       (done),
    .pc_changed (pc_changed),
    .exception  (exception),
    .cond_true  (cond_true),
    .cnt_skip   (cnt_skip),
    .cnt_true   (cnt_true),
    .cnt_false  (cnt_false)
);

// File: tb/tb_pkt_dispatch.sv
`timescale 1ns/1ps
module tb_pkt_dispatch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_valid = 1'b0;
    logic [31:0] word_in = '0;
    logic [63:0] test_only_map = '0;
    logic        in_ready, iss_valid;
    logic [1:0]  iss_tag;
    logic [29:0] iss_payload;
    logic [5:0]  iss_index;
    logic        done = 1'b0, pc_changed = 1'b0, exception = 1'b0, cond_true = 1'b0;
    logic [15:0] cnt_skip, cnt_true, cnt_false;

    int checks = 0;
    int fails  = 0;
    int exp_skip = 0, exp_true = 0, exp_false = 0;

    always #2.5 clk = ~clk;

    pkt_dispatch dut (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
        .test_only_map(test_only_map), .in_ready(in_ready), .iss_valid(iss_valid),
        .iss_tag(iss_tag), .iss_payload(iss_payload), .iss_index(iss_index),
        .done(done), .pc_changed(pc_changed), .exception(exception),
        .cond_true(cond_true), .cnt_skip(cnt_skip), .cnt_true(cnt_true),
        .cnt_false(cnt_false)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_pkt(input logic [31:0] w, input logic [63:0] m,
                           input logic pcc, input logic exc, input logic ct, input logic intr);
        logic [14:0] lh, rh;
        logic        lt, rt;
        logic [1:0]  et [2];
        logic [29:0] ep [2];
        int          n, got, guard;
        string       req;
        lh = w[29:15];
        rh = w[14:0];
        lt = m[lh[14:9]];
        rt = m[rh[14:9]];
        et[1] = 2'd0; ep[1] = '0;
        case (w[31:30])
            2'b11: begin req = "R2"; n = 1; et[0] = 2'd3; ep[0] = w[29:0]; end
            2'b10: begin
                req = "R3"; et[0] = 2'd2; ep[0] = 30'(rh); et[1] = 2'd1; ep[1] = 30'(lh);
                n = (!pcc && !exc) ? 2 : 1;
                if (pcc && !exc) exp_skip++;
            end
            2'b01: begin
                req = "R3"; et[0] = 2'd1; ep[0] = 30'(lh); et[1] = 2'd2; ep[1] = 30'(rh);
                n = (!pcc && !exc) ? 2 : 1;
                if (pcc && !exc) exp_skip++;
            end
            default: begin
                if (lt || rt) begin
                    req = lt ? "R5" : "R6";
                    if (lt) begin et[0] = 2'd1; ep[0] = 30'(lh); et[1] = 2'd2; ep[1] = 30'(rh); end
                    else    begin et[0] = 2'd2; ep[0] = 30'(rh); et[1] = 2'd1; ep[1] = 30'(lh); end
                    n = ct ? 2 : 1;
                    if (ct) exp_true++; else exp_false++;
                end else begin
                    req = "R7"; et[0] = 2'd1; ep[0] = 30'(lh); et[1] = 2'd2; ep[1] = 30'(rh);
                    n = exc ? 1 : 2;
                end
            end
        endcase
        test_only_map = m;
        @(negedge clk);
        word_in = w; word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        got = 0; guard = 0;
        while (!in_ready && guard < 40) begin
            guard++;
            if (iss_valid) begin
                if (got < 2) begin
                    chk(req, "issue tag+payload", {iss_tag, iss_payload}, {et[got], ep[got]});
                    chk("R8", "issue index", iss_index,
                        (et[got] == 2'd3) ? ep[got][29:24] : ep[got][14:9]);
                end
                got++;
                if (intr) begin word_in = ~w; word_valid = 1'b1; end  // R9 stray word while busy
                @(negedge clk);
                word_valid = 1'b0;
                done = 1'b1; pc_changed = pcc; exception = exc; cond_true = ct;
                @(negedge clk);
                done = 1'b0; pc_changed = 1'b0; exception = 1'b0; cond_true = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk(intr ? "R9" : req, "issue count", got, n);
        chk("R10", "ready/idle after packet", {in_ready, iss_valid}, 2'b10);
        chk("R4", "cnt_skip", cnt_skip, exp_skip);
        chk("R5", "cnt_true", cnt_true, exp_true);
        chk("R5", "cnt_false", cnt_false, exp_false);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R9 watchdog: actual hung expected finished run");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "reset ready/valid", {in_ready, iss_valid}, 2'b10);
        chk("R1", "reset counters", {cnt_skip, cnt_true, cnt_false}, 48'd0);
        for (int md = 0; md < 4; md++) begin
            for (int lr = 0; lr < 4; lr++) begin
                for (int fb = 0; fb < 8; fb++) begin
                    logic [5:0]  a, b;
                    logic [8:0]  lo_l, lo_r;
                    logic [63:0] m;
                    logic [31:0] w;
                    a = 6'((md * 16 + lr * 4 + fb * 7) & 63);
                    b = a ^ 6'h2A;
                    lo_l = 9'(fb * 37 + lr * 11 + md * 5);
                    lo_r = 9'(fb * 53 + lr * 3 + 101);
                    m = (64'd1 << (a ^ 6'h01)) | (64'd1 << (b ^ 6'h01));
                    if (lr[1]) m = m | (64'd1 << a);
                    if (lr[0]) m = m | (64'd1 << b);
                    w = {2'(md), a, lo_l, b, lo_r};
                    run_pkt(w, m, fb[0], fb[1], fb[2], fb == 5);
                end
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule